// File: doc/BRIEF.md
# Rail Supply Monitor with Hysteresis and Fault Persistence

This block watches several supply rails whose voltages reach it as digital samples from one shared, time-multiplexed converter. Each sample arrives with a channel index and a valid strobe, and the channels come in round-robin order. Every sample updates only the state of its own channel. That channel is then refreshed once per scan round.

Each channel keeps three status flags: rail good, undervoltage and overvoltage. Every flag has a separate set level and clear level, so a flag that is set stays set while the rail sits between the two levels. Undervoltage and loss of rail good become latched faults only after they persist for a configured number of consecutive samples of that channel. Overvoltage latches a fault on the same sample that shows it, with no filtering. A sequencer reads a combined fault indication, a type code and the channel that raised it, and it clears the faults with a pulse. All thresholds and filter lengths are static configuration inputs.

Top module: `rail_monitor`

## Requirements
- R1: During reset and right after it, every status flag and every fault flag is 0, `fault_any` is 0, `fault_code` is 0 and `fault_chan` is 0.
- R2: On a sample of channel i, `pg_good[i]` sets when the value is >= `thr_pg_rise[i]` and clears when the value is < `thr_pg_fall[i]`. A value between the two levels leaves the flag unchanged.
- R3: On a sample of channel i, `uv_status[i]` sets when the value is <= `thr_uv_fall[i]` and clears when the value is > `thr_uv_rise[i]`. A value between the two levels leaves the flag unchanged.
- R4: On a sample of channel i, `ov_status[i]` sets when the value is >= `thr_ov_rise[i]` and clears when the value is < `thr_ov_fall[i]`. Any sample that leaves `ov_status[i]` set latches `fault_ov[i]` on that same update, with no filtering.
- R5: `fault_uv[i]` latches on the `filt_uv`-th consecutive sample of channel i that leaves `uv_status[i]` set. A limit of 0 acts like 1. Any sample of channel i with the flag clear resets the run. Samples of other channels do not break the run, and the count saturates at its maximum.
- R6: Channel i counts for loss of rail good only after `pg_good[i]` has been set once since reset. After that, `fault_pg[i]` latches on the `filt_pg`-th consecutive sample of channel i that leaves `pg_good[i]` clear. The run resets in the same way as in R5.
- R7: Fault flags hold until `fault_clr` is high at a clock edge, which clears them. A fault that is set on that same edge stays set.
- R8: `fault_code` is 3 for overvoltage, 2 for undervoltage, 1 for rail-good loss and 0 for none. The highest class present wins. `fault_chan` is the lowest channel index that has a fault of that class. `fault_any` is 1 when any fault flag is set.
- R9: A valid sample whose channel index is `NCH` or above changes no flag.
- R10: All flags change on the clock edge that captures a valid sample. Only the addressed channel changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_chan | input | CHW | Channel index of the sample |
| smp_data | input | SW | Sample value |
| thr_pg_rise | input | NCH*SW | Per-channel level at which rail good sets |
| thr_pg_fall | input | NCH*SW | Per-channel level below which rail good clears |
| thr_uv_fall | input | NCH*SW | Per-channel level at or below which undervoltage sets |
| thr_uv_rise | input | NCH*SW | Per-channel level above which undervoltage clears |
| thr_ov_rise | input | NCH*SW | Per-channel level at which overvoltage sets |
| thr_ov_fall | input | NCH*SW | Per-channel level below which overvoltage clears |
| filt_uv | input | FW | Consecutive samples needed for an undervoltage fault |
| filt_pg | input | FW | Consecutive samples needed for a rail-good-loss fault |
| fault_clr | input | 1 | Clears the latched faults |
| pg_good | output | NCH | Rail-good status per channel |
| uv_status | output | NCH | Undervoltage status per channel |
| ov_status | output | NCH | Overvoltage status per channel |
| fault_ov | output | NCH | Latched overvoltage faults |
| fault_uv | output | NCH | Latched undervoltage faults |
| fault_pg | output | NCH | Latched rail-good-loss faults |
| fault_any | output | 1 | Any fault latched |
| fault_code | output | 2 | Type of the highest-priority fault |
| fault_chan | output | CHW | Channel of the reported fault |

## Verification
The properties assume that thresholds and filter lengths stay constant while out of reset. They also assume that each set level sits on the correct side of its clear level (rise >= fall for rail good and overvoltage, fall <= rise for undervoltage). Channel index and value are taken to be meaningful only while the strobe is high. The stimulus programs every channel with one ordered set of levels and never changes it. It drives the strobe, index, value and clear on the falling edge and drops them after the capturing edge. It also sends indices above the channel count only as deliberate out-of-range samples.

// File: rtl/rmon_pkg.sv
package rmon_pkg;
   typedef enum logic [1:0] {
      FC_NONE   = 2'd0,
      FC_PGLOSS = 2'd1,
      FC_UNDER  = 2'd2,
      FC_OVER   = 2'd3
   } fault_code_e;
endpackage

// File: rtl/rmon_hyst.sv
// One hysteretic comparator bit. ABOVE selects whether the flag sets on
// high values (rail good, overvoltage) or on low values (undervoltage).
module rmon_hyst #(
   parameter int SW    = 10,
   parameter bit ABOVE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic [SW-1:0] data,
   input  logic [SW-1:0] set_lvl,
   input  logic [SW-1:0] clr_lvl,
   output logic          state_q,
   output logic          state_nx
);
   logic set_hit;
   logic clr_hit;

   generate
      if (ABOVE) begin : g_above
         assign set_hit = (data >= set_lvl);
         assign clr_hit = (data <  clr_lvl);
      end else begin : g_below
         assign set_hit = (data <= set_lvl);
         assign clr_hit = (data >  clr_lvl);
      end
   endgenerate

   always_comb begin
      state_nx = state_q;
      if (upd) begin
         if (set_hit)      state_nx = 1'b1;
         else if (clr_hit) state_nx = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= 1'b0;
      else        state_q <= state_nx;
   end
endmodule

// File: rtl/rmon_filter.sv
// Persistence filter: counts consecutive violating updates, saturating.
module rmon_filter #(
   parameter int FW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd,
   input  logic          viol,
   input  logic [FW-1:0] limit,
   output logic          trip
);
   localparam logic [FW-1:0] CNT_MAX = '1;

   logic [FW-1:0] cnt_q;
   logic [FW-1:0] cnt_nx;

   always_comb begin
      cnt_nx = cnt_q;
      if (upd) begin
         if (!viol)                cnt_nx = '0;
         else if (cnt_q != CNT_MAX) cnt_nx = cnt_q + 1'b1;
      end
   end

   assign trip = upd & viol & (cnt_nx >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nx;
   end
endmodule

// File: rtl/rmon_prio.sv
// Selects the fault class by severity, then the lowest channel within it.
module rmon_prio
   import rmon_pkg::*;
#(
   parameter int NCH = 5,
   parameter int CHW = 3
) (
   input  logic [NCH-1:0] f_ov,
   input  logic [NCH-1:0] f_uv,
   input  logic [NCH-1:0] f_pg,
   output fault_code_e    code,
   output logic [CHW-1:0] chan
);
   logic [NCH-1:0] sel;

   always_comb begin
      if (|f_ov) begin
         sel  = f_ov;
         code = FC_OVER;
      end else if (|f_uv) begin
         sel  = f_uv;
         code = FC_UNDER;
      end else if (|f_pg) begin
         sel  = f_pg;
         code = FC_PGLOSS;
      end else begin
         sel  = '0;
         code = FC_NONE;
      end
      chan = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (sel[i]) chan = CHW'(i);
      end
   end
endmodule

// File: rtl/rail_monitor.sv
module rail_monitor
   import rmon_pkg::*;
#(
   parameter int NCH = 5,
   parameter int CHW = 3,
   parameter int SW  = 10,
   parameter int FW  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic [CHW-1:0]     smp_chan,
   input  logic [SW-1:0]      smp_data,
   input  logic [NCH*SW-1:0]  thr_pg_rise,
   input  logic [NCH*SW-1:0]  thr_pg_fall,
   input  logic [NCH*SW-1:0]  thr_uv_fall,
   input  logic [NCH*SW-1:0]  thr_uv_rise,
   input  logic [NCH*SW-1:0]  thr_ov_rise,
   input  logic [NCH*SW-1:0]  thr_ov_fall,
   input  logic [FW-1:0]      filt_uv,
   input  logic [FW-1:0]      filt_pg,
   input  logic               fault_clr,
   output logic [NCH-1:0]     pg_good,
   output logic [NCH-1:0]     uv_status,
   output logic [NCH-1:0]     ov_status,
   output logic [NCH-1:0]     fault_ov,
   output logic [NCH-1:0]     fault_uv,
   output logic [NCH-1:0]     fault_pg,
   output logic               fault_any,
   output logic [1:0]         fault_code,
   output logic [CHW-1:0]     fault_chan
);
   localparam int CH_SPAN = 1 << CHW;

   generate
      if (NCH < 1 || NCH > CH_SPAN) begin : g_bad_nch
         $error("rail_monitor: NCH must be between 1 and 2**CHW");
      end
      if (SW < 2) begin : g_bad_sw
         $error("rail_monitor: SW must be at least 2");
      end
      if (FW < 1) begin : g_bad_fw
         $error("rail_monitor: FW must be at least 1");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_ch
         logic hit;
         logic pg_nx, uv_nx, ov_nx;
         logic pg_q, uv_q, ov_q;
         logic armed_q;
         logic uv_trip, pg_trip;
         logic fov_q, fuv_q, fpg_q;

         assign hit = smp_valid && (smp_chan == CHW'(gi));

         rmon_hyst #(.SW(SW), .ABOVE(1'b1)) u_pg (
            .clk(clk), .rst_n(rst_n), .upd(hit), .data(smp_data),
            .set_lvl(thr_pg_rise[gi*SW +: SW]), .clr_lvl(thr_pg_fall[gi*SW +: SW]),
            .state_q(pg_q), .state_nx(pg_nx));

         rmon_hyst #(.SW(SW), .ABOVE(1'b0)) u_uv (
            .clk(clk), .rst_n(rst_n), .upd(hit), .data(smp_data),
            .set_lvl(thr_uv_fall[gi*SW +: SW]), .clr_lvl(thr_uv_rise[gi*SW +: SW]),
            .state_q(uv_q), .state_nx(uv_nx));

         rmon_hyst #(.SW(SW), .ABOVE(1'b1)) u_ov (
            .clk(clk), .rst_n(rst_n), .upd(hit), .data(smp_data),
            .set_lvl(thr_ov_rise[gi*SW +: SW]), .clr_lvl(thr_ov_fall[gi*SW +: SW]),
            .state_q(ov_q), .state_nx(ov_nx));

         rmon_filter #(.FW(FW)) u_uv_flt (
            .clk(clk), .rst_n(rst_n), .upd(hit), .viol(uv_nx),
            .limit(filt_uv), .trip(uv_trip));

         rmon_filter #(.FW(FW)) u_pg_flt (
            .clk(clk), .rst_n(rst_n), .upd(hit), .viol(armed_q & ~pg_nx),
            .limit(filt_pg), .trip(pg_trip));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               armed_q <= 1'b0;
               fov_q   <= 1'b0;
               fuv_q   <= 1'b0;
               fpg_q   <= 1'b0;
            end else begin
               armed_q <= armed_q | (hit & pg_nx);
               fov_q   <= (hit & ov_nx) | (fov_q & ~fault_clr);
               fuv_q   <= uv_trip       | (fuv_q & ~fault_clr);
               fpg_q   <= pg_trip       | (fpg_q & ~fault_clr);
            end
         end

         assign pg_good[gi]   = pg_q;
         assign uv_status[gi] = uv_q;
         assign ov_status[gi] = ov_q;
         assign fault_ov[gi]  = fov_q;
         assign fault_uv[gi]  = fuv_q;
         assign fault_pg[gi]  = fpg_q;
      end
   endgenerate

   fault_code_e code_w;

   rmon_prio #(.NCH(NCH), .CHW(CHW)) u_prio (
      .f_ov(fault_ov), .f_uv(fault_uv), .f_pg(fault_pg),
      .code(code_w), .chan(fault_chan));

   assign fault_code = code_w;
   assign fault_any  = |{fault_ov, fault_uv, fault_pg};
endmodule

// File: rtl/rail_monitor_chk.sv
module rail_monitor_chk #(
   parameter int NCH = 5,
   parameter int CHW = 3,
   parameter int SW  = 10,
   parameter int FW  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic [CHW-1:0]    smp_chan,
   input logic [SW-1:0]     smp_data,
   input logic [NCH*SW-1:0] thr_pg_rise,
   input logic [NCH*SW-1:0] thr_ov_rise,
   input logic              fault_clr,
   input logic [NCH-1:0]    pg_good,
   input logic [NCH-1:0]    uv_status,
   input logic [NCH-1:0]    ov_status,
   input logic [NCH-1:0]    fault_ov,
   input logic [NCH-1:0]    fault_uv,
   input logic [NCH-1:0]    fault_pg,
   input logic              fault_any,
   input logic [1:0]        fault_code
);
   genvar gi;
   generate
      for (gi = 0; gi < NCH; gi++) begin : g_a
         assert_pg_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && smp_chan == CHW'(gi) && smp_data >= thr_pg_rise[gi*SW +: SW])
            |=> pg_good[gi]);
         assert_ov_unfiltered_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && smp_chan == CHW'(gi) && smp_data >= thr_ov_rise[gi*SW +: SW])
            |=> fault_ov[gi]);
      end
   endgenerate

   assert_hold_ov_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_clr |=> ((fault_ov & $past(fault_ov)) == $past(fault_ov)));
   assert_hold_uv_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_clr |=> ((fault_uv & $past(fault_uv)) == $past(fault_uv)));
   assert_hold_pg_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_clr |=> ((fault_pg & $past(fault_pg)) == $past(fault_pg)));
   assert_clear_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_clr && !smp_valid) |=> (fault_ov == '0 && fault_uv == '0 && fault_pg == '0));
   assert_any_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_any == (fault_code != 2'd0));
   assert_ov_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault_ov) |-> (fault_code == 2'd3));
   assert_ignore_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && {1'b0, smp_chan} >= (CHW+1)'(NCH) && !fault_clr)
      |=> ($stable(pg_good) && $stable(uv_status) && $stable(ov_status)
           && $stable(fault_ov) && $stable(fault_uv) && $stable(fault_pg)));
endmodule

bind rail_monitor rail_monitor_chk #(.NCH(NCH), .CHW(CHW), .SW(SW), .FW(FW)) u_chk (.*);

// File: tb/rail_monitor_tb.sv
`timescale 1ns/1ps
module rail_monitor_tb;
   localparam int NCH = 5;
   localparam int CHW = 3;
   localparam int SW  = 10;
   localparam int FW  = 4;
   localparam int PGR = 900, PGF = 860, UVF = 800, UVR = 840, OVR = 1000, OVF = 960;
   localparam int FLT_UV = 3, FLT_PG = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic [CHW-1:0] smp_chan = '0;
   logic [SW-1:0]  smp_data = '0;
   logic fault_clr = 1'b0;
   logic [NCH-1:0] pg_good, uv_status, ov_status, fault_ov, fault_uv, fault_pg;
   logic fault_any;
   logic [1:0] fault_code;
   logic [CHW-1:0] fault_chan;

   always #10 clk = ~clk;

   rail_monitor #(.NCH(NCH), .CHW(CHW), .SW(SW), .FW(FW)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
      .thr_pg_rise({NCH{SW'(PGR)}}), .thr_pg_fall({NCH{SW'(PGF)}}),
      .thr_uv_fall({NCH{SW'(UVF)}}), .thr_uv_rise({NCH{SW'(UVR)}}),
      .thr_ov_rise({NCH{SW'(OVR)}}), .thr_ov_fall({NCH{SW'(OVF)}}),
      .filt_uv(FW'(FLT_UV)), .filt_pg(FW'(FLT_PG)), .fault_clr(fault_clr),
      .pg_good(pg_good), .uv_status(uv_status), .ov_status(ov_status),
      .fault_ov(fault_ov), .fault_uv(fault_uv), .fault_pg(fault_pg),
      .fault_any(fault_any), .fault_code(fault_code), .fault_chan(fault_chan));

   typedef struct {
      logic [NCH-1:0] pg, uv, ov, fov, fuv, fpg;
      logic any;
      logic [1:0] code;
      logic [CHW-1:0] chan;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int failures = 0;

   logic [NCH-1:0] m_pg = '0, m_uv = '0, m_ov = '0, m_arm = '0;
   logic [NCH-1:0] m_fov = '0, m_fuv = '0, m_fpg = '0;
   int c_uv[NCH];
   int c_pg[NCH];

   task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
      end
   endtask

   function automatic exp_t snapshot(input string tag);
      exp_t e;
      logic [NCH-1:0] sel;
      e.pg = m_pg; e.uv = m_uv; e.ov = m_ov;
      e.fov = m_fov; e.fuv = m_fuv; e.fpg = m_fpg;
      e.any = |{m_fov, m_fuv, m_fpg};
      if (|m_fov)      begin sel = m_fov; e.code = 2'd3; end
      else if (|m_fuv) begin sel = m_fuv; e.code = 2'd2; end
      else if (|m_fpg) begin sel = m_fpg; e.code = 2'd1; end
      else             begin sel = '0;    e.code = 2'd0; end
      e.chan = '0;
      for (int k = NCH - 1; k >= 0; k--) if (sel[k]) e.chan = CHW'(k);
      e.tag = tag;
      return e;
   endfunction

   // Reference model written from R2..R9
   task automatic model(input int ch, input int d, input bit clr);
      logic [NCH-1:0] s_ov = '0, s_uv = '0, s_pg = '0;
      if (ch >= 0 && ch < NCH) begin
         logic pgn, uvn, ovn, viol_pg;
         pgn = m_pg[ch]; if (d >= PGR) pgn = 1'b1; else if (d < PGF) pgn = 1'b0;
         uvn = m_uv[ch]; if (d <= UVF) uvn = 1'b1; else if (d > UVR) uvn = 1'b0;
         ovn = m_ov[ch]; if (d >= OVR) ovn = 1'b1; else if (d < OVF) ovn = 1'b0;
         s_ov[ch] = ovn;
         c_uv[ch] = uvn ? ((c_uv[ch] < 15) ? c_uv[ch] + 1 : 15) : 0;
         s_uv[ch] = uvn && (c_uv[ch] >= FLT_UV);
         viol_pg = m_arm[ch] && !pgn;
         c_pg[ch] = viol_pg ? ((c_pg[ch] < 15) ? c_pg[ch] + 1 : 15) : 0;
         s_pg[ch] = viol_pg && (c_pg[ch] >= FLT_PG);
         m_arm[ch] = m_arm[ch] | pgn;
         m_pg[ch] = pgn; m_uv[ch] = uvn; m_ov[ch] = ovn;
      end
      m_fov = s_ov | (m_fov & ~{NCH{clr}});
      m_fuv = s_uv | (m_fuv & ~{NCH{clr}});
      m_fpg = s_pg | (m_fpg & ~{NCH{clr}});
   endtask

   // Driver: ch < 0 means no sample (clear-only cycle)
   task automatic send(input int ch, input int d, input bit clr, input string tag);
      @(negedge clk);
      smp_valid = (ch >= 0);
      smp_chan  = (ch >= 0) ? CHW'(ch) : '0;
      smp_data  = SW'(d);
      fault_clr = clr;
      @(posedge clk);
      model(ch, d, clr);
      q.push_back(snapshot(tag));
      #1;
      smp_valid = 1'b0;
      fault_clr = 1'b0;
   endtask

   // Monitor: results appear one edge after capture (R10)
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(e.tag, "pg_good",    32'(pg_good),    32'(e.pg));
         chk(e.tag, "uv_status",  32'(uv_status),  32'(e.uv));
         chk(e.tag, "ov_status",  32'(ov_status),  32'(e.ov));
         chk(e.tag, "fault_ov",   32'(fault_ov),   32'(e.fov));
         chk(e.tag, "fault_uv",   32'(fault_uv),   32'(e.fuv));
         chk(e.tag, "fault_pg",   32'(fault_pg),   32'(e.fpg));
         chk(e.tag, "fault_any",  32'(fault_any),  32'(e.any));
         chk(e.tag, "fault_code", 32'(fault_code), 32'(e.code));
         chk(e.tag, "fault_chan", 32'(fault_chan), 32'(e.chan));
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int k = 0; k < NCH; k++) begin c_uv[k] = 0; c_pg[k] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "flags", 32'({pg_good, uv_status, ov_status}), 32'd0);
      chk("R1", "faults", 32'({fault_ov, fault_uv, fault_pg}), 32'd0);
      chk("R1", "report", 32'({fault_any, fault_code, fault_chan}), 32'd0);

      // R2/R10: each rail rises to good, one channel at a time
      for (int k = 0; k < NCH; k++) send(k, 920, 1'b0, "R2_R10_rise");
      send(0, 880, 1'b0, "R2_between_holds");
      send(0, 850, 1'b0, "R2_fall_clears");
      send(2, 930, 1'b0, "R6_other_channel");
      send(0, 850, 1'b0, "R6_pgloss_trips");
      send(-1, 0, 1'b1, "R7_clear_idle");
      // R3/R5: undervoltage hysteresis and persistence
      send(1, 790, 1'b0, "R3_uv_set");
      send(1, 820, 1'b0, "R3_uv_between");
      send(-1, 0, 1'b1, "R7_clear_pg1");
      send(1, 850, 1'b0, "R3_uv_clear");
      send(1, 790, 1'b0, "R5_uv_run1");
      send(3, 930, 1'b0, "R5_other_ch");
      send(1, 790, 1'b0, "R5_uv_run2");
      send(1, 795, 1'b0, "R5_uv_trip");
      // R4/R8: overvoltage is immediate and outranks others
      send(3, 1005, 1'b0, "R4_R8_ov_immediate");
      send(3, 980, 1'b0, "R4_ov_between");
      send(3, 950, 1'b0, "R4_R7_ov_clear_fault_held");
      send(4, 1010, 1'b0, "R8_lowest_chan");
      // R9: out-of-range channels ignored
      send(5, 1020, 1'b0, "R9_chan5");
      send(6, 100, 1'b0, "R9_chan6");
      send(7, 1020, 1'b0, "R9_chan7");
      // R7: new overvoltage at the clear edge survives
      send(4, 1010, 1'b1, "R7_set_beats_clear");
      send(-1, 0, 1'b1, "R7_clear_all");
      send(2, 600, 1'b0, "R8_uv_code_check");
      wait (q.size() == 0);
      @(negedge clk);
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule